// File: doc/BRIEF.md
# Configurable GPIO Port Pad Controller

This block holds the digital control for one eight-pin general-purpose port. Software programs it through a small register interface: a data latch for the outputs, a per-pin mode that picks analog or digital, a per-pin drive style that picks push-pull or open-drain, a per-pin alternate-function select, and two global bits. One global bit enables the crossbar and the other turns off every weak pull-up. For each pin the block drives four pad controls: high-side driver enable, low-side driver enable, weak pull-up enable and digital receiver enable. It also samples the raw pad level.

Each pin's output value comes from the data latch, or from an alternate-function input when that pin's select bit is set. This routing applies only once the crossbar is enabled. Until then every pin is held high-impedance. A read of the pin-state register returns the pad levels after a two-flop synchronizer, with pins in analog mode forced to 0. Register writes take effect on the clock edge where the write strobe is sampled, and reads are combinational from the selected register.

Register map (3-bit address, data NUM_PINS wide):

| Address | Register | Reset | Notes |
|---|---|---|---|
| 0 | data latch | all ones | output values |
| 1 | pin state | n/a | read only, writes ignored |
| 2 | digital mode | all ones | 1 = digital, 0 = analog |
| 3 | push-pull mode | all zeros | 1 = push-pull, 0 = open-drain |
| 4 | alternate select | all zeros | 1 = take the output value from the alternate-function input |
| 5 | control | 0 | bit 0 enables the crossbar, bit 1 disables pull-ups |

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the data latch reads all ones, digital mode reads all ones, push-pull mode reads all zeros, alternate select reads all zeros and control reads 0.
- R2: While the crossbar-enable bit (control bit 0) is 0, no pin has a driver enabled, whatever the latch holds. Every digital pin has its pull-up (unless disabled globally) and its receiver enabled.
- R3: A pin whose digital-mode bit is 0 has its high-side driver, low-side driver, pull-up and receiver all disabled.
- R4: Reading the pin-state register (address 1) returns 0 for every pin in analog mode, whatever the pad level.
- R5: With the crossbar enabled, a digital push-pull pin enables its high-side driver for output value 1 and its low-side driver for output value 0.
- R6: With the crossbar enabled, a digital open-drain pin never enables its high-side driver. It enables the low-side driver for output value 0 and is high-impedance for output value 1.
- R7: The weak pull-up of a digital pin is enabled exactly when neither driver is enabled and the global pull-up-disable bit is 0. It is never on while the pin drives low.
- R8: Setting the pull-up-disable bit (control bit 1) turns off the pull-ups on all pins.
- R9: A digital pin reads back its pad level, not the latch value, through a two-stage synchronizer. A pad change made before clock edge k shows up on reads after edge k+1.
- R10: With the crossbar enabled, a pin whose alternate-select bit is 1 takes its output value from its alternate-function input instead of the latch. With the crossbar disabled, the alternate inputs have no effect on the pad.
- R11: The high-side and low-side enables of a pin are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_wr_en | input | 1 | write strobe, sampled on the rising edge |
| reg_addr | input | 3 | register address |
| reg_wdata | input | NUM_PINS | write data |
| reg_rdata | output | NUM_PINS | read data for reg_addr (combinational) |
| alt_out | input | NUM_PINS | alternate-function output values |
| pad_in | input | NUM_PINS | raw pad levels |
| pad_hi_en | output | NUM_PINS | high-side driver enables |
| pad_lo_en | output | NUM_PINS | low-side driver enables |
| pad_pu_en | output | NUM_PINS | weak pull-up enables |
| pad_rx_en | output | NUM_PINS | digital receiver enables |

## Verification
The bench goes after the reset window first. It writes a latch of zeros before the crossbar is enabled: a design that drives early would pull pins low at power-up. It compares open-drain and push-pull pins with the same latch pattern. A design that let the high side through in open-drain mode would fight an external pull, and one that kept the pull-up on while driving low would waste current. It mixes analog and digital pins and checks that analog pins report 0 and disable their pull-ups and receivers. It also samples the pin-state register one edge after a pad change and then two edges after. A missing or extra synchronizer stage, or a readback taken from the latch, shows up there.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
   localparam int unsigned REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      RA_LATCH = 3'd0,
      RA_PINS  = 3'd1,
      RA_DIG   = 3'd2,
      RA_PP    = 3'd3,
      RA_ALT   = 3'd4,
      RA_CTRL  = 3'd5
   } reg_addr_e;

   localparam int unsigned CTRL_XBAR_BIT = 0;
   localparam int unsigned CTRL_PUDIS_BIT = 1;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
   import gpio_pad_pkg::*;
#(
   parameter int unsigned NUM_PINS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] addr,
   input  logic [NUM_PINS-1:0]   wdata,
   input  logic [NUM_PINS-1:0]   pins_q,
   output logic [NUM_PINS-1:0]   rdata,
   output logic [NUM_PINS-1:0]   latch_q,
   output logic [NUM_PINS-1:0]   dig_q,
   output logic [NUM_PINS-1:0]   pp_q,
   output logic [NUM_PINS-1:0]   alt_q,
   output logic                  xbar_q,
   output logic                  pudis_q
);
   localparam logic [NUM_PINS-1:0] ALL_ONE = {NUM_PINS{1'b1}};
   localparam logic [NUM_PINS-1:0] ALL_ZERO = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= ALL_ONE;
         dig_q   <= ALL_ONE;
         pp_q    <= ALL_ZERO;
         alt_q   <= ALL_ZERO;
         xbar_q  <= 1'b0;
         pudis_q <= 1'b0;
      end else if (wr_en) begin
         case (reg_addr_e'(addr))
            RA_LATCH: latch_q <= wdata;
            RA_DIG:   dig_q   <= wdata;
            RA_PP:    pp_q    <= wdata;
            RA_ALT:   alt_q   <= wdata;
            RA_CTRL: begin
               xbar_q  <= wdata[CTRL_XBAR_BIT];
               pudis_q <= wdata[CTRL_PUDIS_BIT];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = ALL_ZERO;
      case (reg_addr_e'(addr))
         RA_LATCH: rdata = latch_q;
         RA_PINS:  rdata = pins_q & dig_q;
         RA_DIG:   rdata = dig_q;
         RA_PP:    rdata = pp_q;
         RA_ALT:   rdata = alt_q;
         RA_CTRL: begin
            rdata[CTRL_XBAR_BIT]  = xbar_q;
            rdata[CTRL_PUDIS_BIT] = pudis_q;
         end
         default: rdata = ALL_ZERO;
      endcase
   end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_cell.sv
module gpio_pad_cell (
   input  logic xbar_en,
   input  logic pu_dis,
   input  logic dig,
   input  logic push_pull,
   input  logic latch_v,
   input  logic alt_sel,
   input  logic alt_v,
   output logic hi_en,
   output logic lo_en,
   output logic pu_en,
   output logic rx_en
);
   logic out_v;
   logic drive_ok;

   assign out_v    = alt_sel ? alt_v : latch_v;
   assign drive_ok = xbar_en & dig;
   assign hi_en    = drive_ok & push_pull & out_v;
   assign lo_en    = drive_ok & ~out_v;
   assign pu_en    = dig & ~pu_dis & ~hi_en & ~lo_en;
   assign rx_en    = dig;
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_pad_pkg::*;
#(
   parameter int unsigned NUM_PINS = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr_en,
   input  logic [REG_ADDR_W-1:0] reg_addr,
   input  logic [NUM_PINS-1:0]   reg_wdata,
   output logic [NUM_PINS-1:0]   reg_rdata,
   input  logic [NUM_PINS-1:0]   alt_out,
   input  logic [NUM_PINS-1:0]   pad_in,
   output logic [NUM_PINS-1:0]   pad_hi_en,
   output logic [NUM_PINS-1:0]   pad_lo_en,
   output logic [NUM_PINS-1:0]   pad_pu_en,
   output logic [NUM_PINS-1:0]   pad_rx_en
);
   generate
      if (NUM_PINS < 2 || NUM_PINS > 32) begin : g_bad_pins
         $error("gpio_port_ctrl: NUM_PINS must be 2..32");
      end
      if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("gpio_port_ctrl: SYNC_STAGES must be 2..4");
      end
   endgenerate

   logic [NUM_PINS-1:0] cfg_latch, cfg_dig, cfg_pp, cfg_alt, pin_sync;
   logic                cfg_xbar, cfg_pudis;

   gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
   );

   gpio_cfg_regs #(.NUM_PINS(NUM_PINS)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
      .wdata(reg_wdata), .pins_q(pin_sync), .rdata(reg_rdata),
      .latch_q(cfg_latch), .dig_q(cfg_dig), .pp_q(cfg_pp), .alt_q(cfg_alt),
      .xbar_q(cfg_xbar), .pudis_q(cfg_pudis)
   );

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         gpio_pad_cell cell_i (
            .xbar_en(cfg_xbar), .pu_dis(cfg_pudis), .dig(cfg_dig[p]),
            .push_pull(cfg_pp[p]), .latch_v(cfg_latch[p]), .alt_sel(cfg_alt[p]),
            .alt_v(alt_out[p]), .hi_en(pad_hi_en[p]), .lo_en(pad_lo_en[p]),
            .pu_en(pad_pu_en[p]), .rx_en(pad_rx_en[p])
         );
      end
   endgenerate
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
   parameter int unsigned NUM_PINS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                xbar,
   input logic                pudis,
   input logic [NUM_PINS-1:0] dig,
   input logic [NUM_PINS-1:0] pp,
   input logic [NUM_PINS-1:0] hi,
   input logic [NUM_PINS-1:0] lo,
   input logic [NUM_PINS-1:0] pu,
   input logic [NUM_PINS-1:0] rx
);
   // R11
   hilo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi & lo) == '0);
   // R2
   no_drive_pre_xbar_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xbar |-> ((hi | lo) == '0));
   // R3
   analog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((hi | lo | pu | rx) & ~dig) == '0);
   // R6
   od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi & ~pp) == '0);
   // R7
   pu_not_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pu & lo) == '0);
   // R8
   pu_global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pudis |-> (pu == '0));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NUM_PINS(NUM_PINS)) chk_i (
   .clk(clk), .rst_n(rst_n), .xbar(cfg_xbar), .pudis(cfg_pudis),
   .dig(cfg_dig), .pp(cfg_pp), .hi(pad_hi_en), .lo(pad_lo_en),
   .pu(pad_pu_en), .rx(pad_rx_en)
);

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr_en = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic [7:0] alt_out = 8'h00;
   logic [7:0] pad_in = 8'hFF;
   logic [7:0] pad_hi_en, pad_lo_en, pad_pu_en, pad_rx_en;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gpio_port_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alt_out(alt_out),
      .pad_in(pad_in), .pad_hi_en(pad_hi_en), .pad_lo_en(pad_lo_en),
      .pad_pu_en(pad_pu_en), .pad_rx_en(pad_rx_en)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic pad_chk(input string req, input logic [7:0] h, input logic [7:0] l,
                          input logic [7:0] p, input logic [7:0] r);
      #1;
      chk({req, " hi"}, pad_hi_en, h);
      chk({req, " lo"}, pad_lo_en, l);
      chk({req, " pu"}, pad_pu_en, p);
      chk({req, " rx"}, pad_rx_en, r);
      chk("R11 excl", pad_hi_en & pad_lo_en, 8'h00);
   endtask

   task automatic t_reset;
      rd_chk("R1 latch", 3'd0, 8'hFF);
      rd_chk("R1 dig", 3'd2, 8'hFF);
      rd_chk("R1 pp", 3'd3, 8'h00);
      rd_chk("R1 alt", 3'd4, 8'h00);
      rd_chk("R1 ctrl", 3'd5, 8'h00);
      pad_chk("R2 reset", 8'h00, 8'h00, 8'hFF, 8'hFF);
      wr(3'd0, 8'h00);
      wr(3'd3, 8'hFF);
      pad_chk("R2 latch0 no xbar", 8'h00, 8'h00, 8'hFF, 8'hFF);
   endtask

   task automatic t_pushpull;
      wr(3'd5, 8'h01);
      wr(3'd3, 8'hFF);
      wr(3'd0, 8'hA5);
      pad_chk("R5 R7 pushpull", 8'hA5, 8'h5A, 8'h00, 8'hFF);
   endtask

   task automatic t_opendrain;
      wr(3'd3, 8'h00);
      pad_chk("R6 R7 opendrain", 8'h00, 8'h5A, 8'hA5, 8'hFF);
   endtask

   task automatic t_analog;
      wr(3'd3, 8'hFF);
      wr(3'd0, 8'hFF);
      wr(3'd2, 8'h0F);
      pad_chk("R3 analog", 8'h0F, 8'h00, 8'h00, 8'h0F);
      @(negedge clk); pad_in = 8'hFF;
      repeat (3) @(negedge clk);
      rd_chk("R4 analog reads 0", 3'd1, 8'h0F);
      wr(3'd2, 8'hFF);
   endtask

   task automatic t_input;
      wr(3'd3, 8'h00);
      wr(3'd0, 8'h00);
      repeat (3) @(negedge clk);
      rd_chk("R9 pad not latch", 3'd1, 8'hFF);
      pad_in = 8'h3C;
      @(negedge clk);
      rd_chk("R9 after one edge", 3'd1, 8'hFF);
      @(negedge clk);
      rd_chk("R9 after two edges", 3'd1, 8'h3C);
   endtask

   task automatic t_pudis;
      wr(3'd0, 8'hFF);
      wr(3'd5, 8'h03);
      pad_chk("R8 pudis", 8'h00, 8'h00, 8'h00, 8'hFF);
      wr(3'd5, 8'h01);
      pad_chk("R8 pu back", 8'h00, 8'h00, 8'hFF, 8'hFF);
   endtask

   task automatic t_alt;
      wr(3'd3, 8'hFF);
      wr(3'd0, 8'h0F);
      wr(3'd4, 8'hF0);
      alt_out = 8'h50;
      pad_chk("R10 alt mux", 8'h5F, 8'hA0, 8'h00, 8'hFF);
      wr(3'd5, 8'h00);
      pad_chk("R10 alt no xbar", 8'h00, 8'h00, 8'hFF, 8'hFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pushpull();
      t_opendrain();
      t_analog();
      t_input();
      t_pudis();
      t_alt();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule